// File: doc/BRIEF.md
# Programmable-Length SPI Shift Core

This block is a serial peripheral engine that can act as bus master or bus slave. Characters of 1 to 16 bits pass through one 16-bit shift register. Each bit leaves from the top of the register, and the register moves one place toward the top while the incoming bit enters at the bottom. The host writes the shift register directly. It may also park one further character in a one-deep holding register, which refills the shift register as soon as the current character ends. At the end of every character, the whole 16-bit register is copied into a receive buffer. An interrupt flag is raised at the same time, and an overrun flag is raised when the previous result was never read.

As master, the core makes the serial clock from the system clock with a divider of (divisor+1). The divisor field is 7 bits wide, and any value below 3 acts as 3. The clock idles low. Data changes on the falling edge and is captured on the rising edge. As slave, the core synchronises the external clock, data and select lines and shifts only on edges seen while select is low.

Top module: `spi_shift_core`

## Requirements
- R1: After reset, ss_n_o=1, sclk_o=0, busy=0, int_flag=0, ovr_flag=0, irq=0, txh_full=0 and rxb_data=0.
- R2: In master mode, a write to the shift register starts a transfer at once. int_flag rises exactly (cfg_len+1)*P clocks after the write edge, where P = max(cfg_brr,3)+1.
- R3: The bit sent first is bit 15, and received bits enter at bit 0. At completion, rxb_data holds the full register after cfg_len+1 left shifts, so with MISO tied to MOSI it equals the written word rotated left by cfg_len+1.
- R4: sclk_o is low when no character is being shifted. Within each bit period of P clocks it is low for floor(P/2) clocks and then high, so one character gives (cfg_len+1)*(P-floor(P/2)) high clocks, and sclk_o is never high while ss_n_o is high.
- R5: int_flag is set at completion and cleared by rxb_rd. irq equals int_flag AND int_en.
- R6: A completion while int_flag is still set (and not read in that cycle) sets ovr_flag. ovr_clr=1 clears it.
- R7: A txh_wr during a transfer fills the holding register (txh_full=1). At completion, that word is loaded and shifted next with ss_n_o kept low, and txh_full returns to 0.
- R8: A txh_wr while the master is not shifting starts a transfer directly, and the holding register stays empty.
- R9: ss_n_o goes low with the start and goes high exactly P clocks after the last completion. busy falls at the same edge.
- R10: In slave mode, the core captures mosi_i on rising sclk_i and shifts on falling sclk_i while ss_n_i is low. miso_o is bit 15 of the shift register. Each half period of sclk_i must be at least 4 system clocks.
- R11: A shift-register write during a transfer overwrites the register without restarting the bit count, so the completion time stays that of the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_len | input | 4 | Character length minus one |
| cfg_brr | input | 7 | Clock divisor; bit period is max(value,3)+1 clocks |
| int_en | input | 1 | Interrupt enable |
| dat_wr | input | 1 | Write strobe for the shift register |
| dat_wdata | input | 16 | Shift register write data (left-justified) |
| txh_wr | input | 1 | Write strobe for the holding register |
| txh_wdata | input | 16 | Holding register write data (left-justified) |
| rxb_rd | input | 1 | Receive buffer read strobe; clears int_flag |
| ovr_clr | input | 1 | Write-one clear for ovr_flag |
| rxb_data | output | 16 | Receive buffer |
| int_flag | output | 1 | Character complete flag |
| ovr_flag | output | 1 | Receive overrun flag |
| irq | output | 1 | Interrupt request |
| txh_full | output | 1 | Holding register occupied |
| busy | output | 1 | Transfer in progress (master) or selected (slave) |
| sclk_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Serial data out as master |
| ss_n_o | output | 1 | Active-low select driven as master |
| miso_o | output | 1 | Serial data out as slave |
| sclk_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Serial data in as slave |
| miso_i | input | 1 | Serial data in as master |
| ss_n_i | input | 1 | Active-low select received as slave |

## Verification
If the bit counter is wrong, int_flag rises at the wrong clock. The bench catches this on the first character, because it counts clocks exactly. A fault in the divider shows up within one bit period as a changed count of high sclk_o clocks. A fault in the shift direction or the capture point shows up in rxb_data at the first completion: loopback and master-slave pairs give known rotations and splices of the two words. Faults in the flags or the holding register show up at the second completion of a back-to-back pair.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;

    localparam int unsigned BRR_FLOOR = 3;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_TAIL = 2'd2
    } mst_state_e;

    typedef struct packed {
        logic lvl;      // serial clock level for the current count
        logic smp_pt;   // count at which the rising edge happens next
        logic bit_end;  // last count of the bit period
    } baud_tick_t;

    function automatic logic [15:0] bit_period(input logic [15:0] brr);
        logic [15:0] eff;
        eff = (brr < 16'(BRR_FLOOR)) ? 16'(BRR_FLOOR) : brr;
        return eff + 16'd1;
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_core_pkg::*;
#(
    parameter int BRR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [BRR_W-1:0] brr,
    output baud_tick_t       tick
);
    localparam int CW = BRR_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;
    logic [CW-1:0] half;

    always_comb begin
        period       = CW'(bit_period(16'(brr)));
        half         = period >> 1;
        tick.bit_end = run && (cnt == period - 1'b1);
        tick.smp_pt  = run && (cnt == half - 1'b1);
        tick.lvl     = run && (cnt >= half);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (tick.bit_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_core_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             ld_en,
    input  logic [DW-1:0]    ld_data,
    input  logic             hold_full,
    input  logic [DW-1:0]    hold_data,
    output logic             hold_take,
    input  baud_tick_t       tick,
    output logic             run,
    output logic             restart,
    output logic             can_start,
    input  logic             sclk_i,
    input  logic             mosi_i,
    input  logic             miso_i,
    input  logic             ss_n_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             miso_o,
    output logic             ss_n_o,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    done_data
);
    mst_state_e       state;
    logic [DW-1:0]    sr;
    logic [LEN_W-1:0] bitcnt;
    logic             smp;
    logic [2:0]       sck_q;
    logic [1:0]       mosi_q;
    logic [1:0]       ss_q;

    logic s_rise, s_fall, s_sel;
    logic shift_ev, sample_ev, sample_src, last;

    always_comb begin
        s_rise     = sck_q[1] & ~sck_q[2];
        s_fall     = ~sck_q[1] & sck_q[2];
        s_sel      = ~ss_q[1];
        run        = cfg_master && (state != MS_IDLE);
        can_start  = cfg_master && (state != MS_RUN);
        restart    = ld_en && can_start;
        shift_ev   = cfg_master ? (state == MS_RUN && tick.bit_end) : (s_sel && s_fall);
        sample_ev  = cfg_master ? (state == MS_RUN && tick.smp_pt) : (s_sel && s_rise);
        sample_src = cfg_master ? miso_i : mosi_q[1];
        last       = (bitcnt == cfg_len);
        done       = shift_ev && last;
        done_data  = {sr[DW-2:0], smp};
        hold_take  = done && hold_full;
        sclk_o     = cfg_master && (state == MS_RUN) && tick.lvl;
        mosi_o     = cfg_master & sr[DW-1];
        miso_o     = ~cfg_master & sr[DW-1];
        ss_n_o     = ~run;
        busy       = cfg_master ? (state != MS_IDLE) : s_sel;
    end

    // slave-side input synchronisers
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            mosi_q <= '0;
            ss_q   <= '1;
        end else begin
            sck_q  <= {sck_q[1:0], sclk_i};
            mosi_q <= {mosi_q[0], mosi_i};
            ss_q   <= {ss_q[0], ss_n_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            smp <= 1'b0;
        end else begin
            if (sample_ev)
                smp <= sample_src;
            if (ld_en)
                sr <= ld_data;
            else if (hold_take)
                sr <= hold_data;
            else if (shift_ev)
                sr <= done_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bitcnt <= '0;
        else if ((!cfg_master && !s_sel) || restart)
            bitcnt <= '0;
        else if (shift_ev)
            bitcnt <= last ? '0 : bitcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_master) begin
            state <= MS_IDLE;
        end else begin
            case (state)
                MS_IDLE: if (restart) state <= MS_RUN;
                MS_RUN:  if (done && !hold_full) state <= MS_TAIL;
                MS_TAIL: begin
                    if (restart)
                        state <= MS_RUN;
                    else if (tick.bit_end)
                        state <= MS_IDLE;
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          txh_wr,
    input  logic [DW-1:0] txh_wdata,
    input  logic          txh_direct,
    input  logic          hold_take,
    output logic          hold_full,
    output logic [DW-1:0] hold_data,
    input  logic          done,
    input  logic [DW-1:0] done_data,
    input  logic          rxb_rd,
    input  logic          ovr_clr,
    input  logic          int_en,
    output logic [DW-1:0] rxb_data,
    output logic          int_flag,
    output logic          ovr_flag,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (txh_wr && !txh_direct) begin
            hold_full <= 1'b1;
            hold_data <= txh_wdata;
        end else if (hold_take) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxb_data <= '0;
            int_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (done) begin
                rxb_data <= done_data;
                int_flag <= 1'b1;
            end else if (rxb_rd) begin
                int_flag <= 1'b0;
            end
            if (done && int_flag && !rxb_rd)
                ovr_flag <= 1'b1;
            else if (ovr_clr)
                ovr_flag <= 1'b0;
        end
    end

    assign irq = int_flag & int_en;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_core_pkg::*;
#(
    parameter int DW    = 16,
    parameter int BRR_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic [$clog2(DW)-1:0] cfg_len,
    input  logic [BRR_W-1:0] cfg_brr,
    input  logic             int_en,
    input  logic             dat_wr,
    input  logic [DW-1:0]    dat_wdata,
    input  logic             txh_wr,
    input  logic [DW-1:0]    txh_wdata,
    input  logic             rxb_rd,
    input  logic             ovr_clr,
    output logic [DW-1:0]    rxb_data,
    output logic             int_flag,
    output logic             ovr_flag,
    output logic             irq,
    output logic             txh_full,
    output logic             busy,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             ss_n_o,
    output logic             miso_o,
    input  logic             sclk_i,
    input  logic             mosi_i,
    input  logic             miso_i,
    input  logic             ss_n_i
);
    localparam int LEN_W = $clog2(DW);

    baud_tick_t    tick;
    logic          run, restart, can_start;
    logic          txh_direct, ld_en;
    logic [DW-1:0] ld_data;
    logic [DW-1:0] hold_data;
    logic          hold_take;
    logic          done;
    logic [DW-1:0] done_data;

    always_comb begin
        txh_direct = txh_wr && can_start && !dat_wr;
        ld_en      = dat_wr || txh_direct;
        ld_data    = dat_wr ? dat_wdata : txh_wdata;
    end

    spi_baud_gen #(.BRR_W(BRR_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (restart),
        .brr     (cfg_brr),
        .tick    (tick)
    );

    spi_shift_engine #(.DW(DW), .LEN_W(LEN_W)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cfg_master(cfg_master),
        .cfg_len   (cfg_len),
        .ld_en     (ld_en),
        .ld_data   (ld_data),
        .hold_full (txh_full),
        .hold_data (hold_data),
        .hold_take (hold_take),
        .tick      (tick),
        .run       (run),
        .restart   (restart),
        .can_start (can_start),
        .sclk_i    (sclk_i),
        .mosi_i    (mosi_i),
        .miso_i    (miso_i),
        .ss_n_i    (ss_n_i),
        .sclk_o    (sclk_o),
        .mosi_o    (mosi_o),
        .miso_o    (miso_o),
        .ss_n_o    (ss_n_o),
        .busy      (busy),
        .done      (done),
        .done_data (done_data)
    );

    spi_host_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .txh_wr    (txh_wr),
        .txh_wdata (txh_wdata),
        .txh_direct(txh_direct),
        .hold_take (hold_take),
        .hold_full (txh_full),
        .hold_data (hold_data),
        .done      (done),
        .done_data (done_data),
        .rxb_rd    (rxb_rd),
        .ovr_clr   (ovr_clr),
        .int_en    (int_en),
        .rxb_data  (rxb_data),
        .int_flag  (int_flag),
        .ovr_flag  (ovr_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/spi_shift_core_chk.sv
module spi_shift_core_chk (
    input logic clk,
    input logic rst,
    input logic cfg_master,
    input logic dat_wr,
    input logic txh_wr,
    input logic int_flag,
    input logic ovr_flag,
    input logic irq,
    input logic txh_full,
    input logic busy,
    input logic sclk_o,
    input logic ss_n_o
);
    // R4
    sclk_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> !ss_n_o);

    // R2
    start_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && $past(cfg_master) && $rose(busy)) |-> ($past(dat_wr) || $past(txh_wr)));

    // R5
    flag_from_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flag) |-> $past(busy));

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> int_flag);

    // R6
    overrun_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(int_flag));

    // R7
    hold_drains_in_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txh_full) |-> $past(busy));

    // R9
    release_after_quiet_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && $past(cfg_master) && $rose(ss_n_o)) |-> !$past(sclk_o));

endmodule

bind spi_shift_core spi_shift_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_master(cfg_master),
    .dat_wr    (dat_wr),
    .txh_wr    (txh_wr),
    .int_flag  (int_flag),
    .ovr_flag  (ovr_flag),
    .irq       (irq),
    .txh_full  (txh_full),
    .busy      (busy),
    .sclk_o    (sclk_o),
    .ss_n_o    (ss_n_o)
);

// File: tb/sim_spi_shift_core.sv
module sim_spi_shift_core;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [3:0]  cfg_len = '0;
    logic [6:0]  cfg_brr = 7'd3;
    logic        lb = 1'b0;

    // master instance signals
    logic        m_int_en = 0, m_dat_wr = 0, m_txh_wr = 0, m_rd = 0, m_oclr = 0;
    logic [15:0] m_dw = '0, m_tw = '0, m_rx;
    logic        m_int, m_ovr, m_irq, m_full, m_busy, m_sclk, m_mosi, m_ss_n, m_miso_unused;
    // slave instance signals
    logic        s_dat_wr = 0, s_rd = 0;
    logic [15:0] s_dw = '0, s_rx;
    logic        s_int, s_ovr, s_irq, s_full, s_busy, s_sclk_unused, s_mosi_unused, s_ss_unused, s_miso;

    logic m_miso_in;
    assign m_miso_in = lb ? m_mosi : s_miso;

    spi_shift_core u0 (
        .clk(clk), .rst(rst), .cfg_master(1'b1), .cfg_len(cfg_len), .cfg_brr(cfg_brr),
        .int_en(m_int_en), .dat_wr(m_dat_wr), .dat_wdata(m_dw), .txh_wr(m_txh_wr),
        .txh_wdata(m_tw), .rxb_rd(m_rd), .ovr_clr(m_oclr), .rxb_data(m_rx),
        .int_flag(m_int), .ovr_flag(m_ovr), .irq(m_irq), .txh_full(m_full), .busy(m_busy),
        .sclk_o(m_sclk), .mosi_o(m_mosi), .ss_n_o(m_ss_n), .miso_o(m_miso_unused),
        .sclk_i(1'b0), .mosi_i(1'b0), .miso_i(m_miso_in), .ss_n_i(1'b1)
    );

    spi_shift_core u1 (
        .clk(clk), .rst(rst), .cfg_master(1'b0), .cfg_len(cfg_len), .cfg_brr(cfg_brr),
        .int_en(1'b0), .dat_wr(s_dat_wr), .dat_wdata(s_dw), .txh_wr(1'b0),
        .txh_wdata(16'h0), .rxb_rd(s_rd), .ovr_clr(1'b0), .rxb_data(s_rx),
        .int_flag(s_int), .ovr_flag(s_ovr), .irq(s_irq), .txh_full(s_full), .busy(s_busy),
        .sclk_o(s_sclk_unused), .mosi_o(s_mosi_unused), .ss_n_o(s_ss_unused), .miso_o(s_miso),
        .sclk_i(m_sclk), .mosi_i(m_mosi), .miso_i(1'b0), .ss_n_i(m_ss_n)
    );

    int checks = 0;
    int errors = 0;
    int wd = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] shl(input logic [15:0] a, input logic [15:0] b, input int n);
        logic [31:0] t;
        t = {a, b} << n;
        return t[31:16];
    endfunction

    function automatic int per(input logic [6:0] b);
        return ((b < 7'd3) ? 3 : int'(b)) + 1;
    endfunction

    task automatic wait_int(output int cyc);
        cyc = 0;
        while (!m_int && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic pulse_rd;
        m_rd = 1; s_rd = 1;
        @(negedge clk);
        m_rd = 0; s_rd = 0;
    endtask

    task automatic wait_release(output int t);
        t = 0;
        while (!m_ss_n && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // one character, master plus slave (or master looped back)
    task automatic xfer(input bit lbi, input int n, input logic [6:0] b,
                        input logic [15:0] md, input logic [15:0] sd);
        int cyc, hi, t, p;
        lb = lbi; cfg_len = 4'(n - 1); cfg_brr = b; p = per(b);
        s_dat_wr = 1; s_dw = sd;
        @(negedge clk);
        s_dat_wr = 0;
        m_dat_wr = 1; m_dw = md;
        @(negedge clk);
        m_dat_wr = 0;
        cyc = 0;
        hi = m_sclk ? 1 : 0;
        while (!m_int && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (m_sclk) hi++;
        end
        chk(cyc == n * p, "R2 completion clock", cyc, n * p);
        chk(hi == n * (p - p / 2), "R4 high clock count", hi, n * (p - p / 2));
        chk(!m_ss_n, "R9 select held after last bit", m_ss_n, 0);
        wait_release(t);
        chk(t == p, "R9 release delay", t, p);
        chk(m_rx == (lbi ? shl(md, md, n) : shl(md, sd, n)), "R3 master receive", m_rx,
            lbi ? shl(md, md, n) : shl(md, sd, n));
        if (!lbi) begin
            chk(s_int && s_rx == shl(sd, md, n), "R10 slave receive", s_rx, shl(sd, md, n));
        end
        pulse_rd;
        chk(!m_int, "R5 read clears flag", m_int, 0);
    endtask

    initial begin
        int cyc, t;
        logic [15:0] a, b;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(m_ss_n && !m_sclk && !m_busy && !m_int && !m_ovr && !m_irq && !m_full && m_rx == 0,
            "R1 reset state", {m_ss_n, m_sclk, m_busy, m_int, m_ovr, m_irq, m_full}, 7'b1000000);

        // R3 R10: master-slave sweep over every length
        for (int n = 1; n <= 16; n++) begin
            a = 16'hA5C3 ^ 16'(n * 16'h1F31);
            b = {a[6:0], a[15:7]} ^ 16'h3C96;
            xfer(1'b0, n, 7'd15, a, b);
        end

        // R2 R4: divider corners in loopback
        xfer(1'b1, 16, 7'd3, 16'hB2E1, 16'h0);
        xfer(1'b1, 4, 7'd0, 16'h9000, 16'h0);
        xfer(1'b1, 5, 7'd4, 16'h6800, 16'h0);
        xfer(1'b1, 2, 7'd127, 16'h4000, 16'h0);
        xfer(1'b1, 9, 7'd6, 16'hD580, 16'h0);

        // R7: holding register reload, no overrun when read in between
        lb = 1; cfg_len = 4'd7; cfg_brr = 7'd3;
        a = 16'hC35A; b = 16'h7E81;
        m_dat_wr = 1; m_dw = a;
        @(negedge clk);
        m_dat_wr = 0; m_txh_wr = 1; m_tw = b;
        @(negedge clk);
        m_txh_wr = 0;
        chk(m_full, "R7 holding occupied", m_full, 1);
        wait_int(cyc);
        chk(m_rx == shl(a, a, 8), "R7 first character", m_rx, shl(a, a, 8));
        chk(!m_ss_n && m_busy && !m_full, "R7 select kept, hold drained", {m_ss_n, m_busy, m_full}, 3'b010);
        pulse_rd;
        wait_int(cyc);
        chk(cyc == 31, "R7 second character timing", cyc, 31);
        chk(m_rx == shl(b, b, 8), "R7 second character", m_rx, shl(b, b, 8));
        chk(!m_ovr, "R6 no overrun when read", m_ovr, 0);
        pulse_rd;
        wait_release(t);

        // R8 and R6: direct start from the holding write, then an overrun
        m_txh_wr = 1; m_tw = 16'h1234;
        @(negedge clk);
        chk(m_busy && !m_full, "R8 direct start", {m_busy, m_full}, 2'b10);
        m_tw = 16'hFEDC;
        @(negedge clk);
        m_txh_wr = 0;
        chk(m_full, "R8 second write held", m_full, 1);
        wait_int(cyc);
        @(negedge clk);
        wait_release(t);
        chk(m_ovr, "R6 overrun set", m_ovr, 1);
        chk(m_rx == shl(16'hFEDC, 16'hFEDC, 8), "R6 latest data kept", m_rx, shl(16'hFEDC, 16'hFEDC, 8));
        chk(!m_irq, "R5 irq masked", m_irq, 0);
        m_int_en = 1;
        @(negedge clk);
        chk(m_irq, "R5 irq enabled", m_irq, 1);
        pulse_rd;
        chk(!m_int && !m_irq, "R5 irq cleared by read", {m_int, m_irq}, 0);
        m_oclr = 1;
        @(negedge clk);
        m_oclr = 0;
        chk(!m_ovr, "R6 overrun cleared", m_ovr, 0);
        m_int_en = 0;

        // R11: overwrite mid-character keeps the original completion time
        cfg_len = 4'd15; cfg_brr = 7'd3;
        m_dat_wr = 1; m_dw = 16'hAAAA;
        @(negedge clk);
        m_dat_wr = 0;
        cyc = 0;
        while (!m_int && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            m_dat_wr = (cyc == 10);
            m_dw = 16'h5555;
        end
        m_dat_wr = 0;
        chk(cyc == 64, "R11 no restart on overwrite", cyc, 64);
        pulse_rd;
        wait_release(t);
        chk(m_ss_n && !m_busy && !m_sclk, "R4 idle low clock", {m_ss_n, m_busy, m_sclk}, 3'b100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule